// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Interface

This block is the digital control side of a two-channel, double-buffered digital-to-analog converter. A host writes 16-bit words over a three-wire SPI-style port: an active-low select, a serial clock and a serial data line. Each word holds a 4-bit command in its top bits and a 12-bit data field below it. Depending on the command, the data is written into a channel's staging register, or a channel's staging value is moved to its output register, or both happen at once. A command can target channel A, channel B or both channels.

All logic runs on one system clock. The three serial pins and the clear pin each pass through a two-flop synchronizer, and serial clock edges are found on the synchronized copies. A word is accepted only when the select line goes high after at least 16 serial clocks. If more than 16 clocks arrive, the last 16 bits are used. The shift register's top bit drives a serial output, so devices can be chained.

The output codes are the two output registers. They are `DAC_BITS` wide (12, 10 or 8) and take the upper bits of the left-justified data field.

Top module: `dual_dac_ctrl`

## Requirements
- R1: A frame is shifted most significant bit first. Bits [15:12] are the command and bits [11:0] are the data. A frame takes effect only after the select line returns high.
- R2: While `cs_n` is high, edges on `sck` do not change the shift register. Bits that `sdo` later shows prove this.
- R3: A frame with fewer than 16 clocks changes no register. A frame with more than 16 clocks is decoded from the last 16 bits shifted in.
- R4: Command 0000 writes the data into staging register A. Command 0001 copies staging A into output A. Command 0010 writes the data into both staging A and output A.
- R5: Commands 0011, 0100 and 0101 perform the same three actions on channel B.
- R6: Commands 1100, 1101 and 1110 perform the same three actions on both channels at once.
- R7: Commands 0110, 0111, 1000, 1001, 1010, 1011 and 1111 leave every staging and output register unchanged.
- R8: An output code changes only through an update action, a clear or a reset. A staging-only write leaves the output code unchanged.
- R9: `sdo` is the shift register's top bit. During any frame, it presents the previous 16 shifted bits, most significant first, one bit before each rising `sck`.
- R10: A low `clr_n`, once synchronized, sets both staging registers, both output registers and the shift register to zero.
- R11: Synchronous reset `rst` sets all registers to zero and the outputs to zero.
- R12: With `DAC_BITS` below 12, an output code equals data bits [11:12-DAC_BITS]. The lower data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, used as power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear pin, synchronized inside the block |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (shift register top bit) |
| dac_a_code | output | DAC_BITS | Output register of channel A |
| dac_b_code | output | DAC_BITS | Output register of channel B |

## Verification
Several properties are checked on every cycle:
- The shift register holds its value while the synchronized select line is high.
- Output codes move only after an update pulse or a clear.
- An update-only pulse copies the staging value.
- No-op commands produce no action pulses.
- Clear and reset zero every register.

Only the bench scenarios can show the command table from end to end through real serial frames. They also cover rejecting short frames, keeping the last 16 bits of long frames, the bit-by-bit `sdo` chaining sequence, and the truncated code of an 8-bit instance.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int FRAME_W = 16;
  localparam int CMD_W   = 4;
  localparam int DATA_W  = FRAME_W - CMD_W;
  localparam int NUM_CH  = 2;

  typedef struct packed {
    logic ld_a;
    logic up_a;
    logic ld_b;
    logic up_b;
  } dac_act_t;

  function automatic dac_act_t decode_cmd(input logic [CMD_W-1:0] c);
    dac_act_t r;
    r = '0;
    case (c)
      4'b0000: r.ld_a = 1'b1;
      4'b0001: r.up_a = 1'b1;
      4'b0010: begin r.ld_a = 1'b1; r.up_a = 1'b1; end
      4'b0011: r.ld_b = 1'b1;
      4'b0100: r.up_b = 1'b1;
      4'b0101: begin r.ld_b = 1'b1; r.up_b = 1'b1; end
      4'b1100: begin r.ld_a = 1'b1; r.ld_b = 1'b1; end
      4'b1101: begin r.up_a = 1'b1; r.up_b = 1'b1; end
      4'b1110: begin
        r.ld_a = 1'b1; r.up_a = 1'b1;
        r.ld_b = 1'b1; r.up_b = 1'b1;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic cmd_is_noop(input logic [CMD_W-1:0] c);
    return (c == 4'b0110) || (c == 4'b0111) || (c[3:2] == 2'b10) || (c == 4'b1111);
  endfunction
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dac_shifter.sv
module dac_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n_s,
  input  logic               sck_s,
  input  logic               sdi_s,
  output logic [FRAME_W-1:0] sreg_q,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic             sck_d;
  logic             cs_d;
  logic [CNT_W-1:0] bit_cnt;
  logic             sck_rise;
  logic             cs_rise;
  logic             cnt_full;

  assign sck_rise = sck_s & ~sck_d & ~cs_n_s;
  assign cs_rise  = cs_n_s & ~cs_d;
  assign cnt_full = (bit_cnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d      <= 1'b0;
      cs_d       <= 1'b1;
      bit_cnt    <= '0;
      sreg_q     <= '0;
      frame_vld  <= 1'b0;
      frame_word <= '0;
    end else begin
      sck_d     <= sck_s;
      cs_d      <= cs_n_s;
      frame_vld <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        sreg_q <= {sreg_q[FRAME_W-2:0], sdi_s};
        if (!cnt_full) bit_cnt <= bit_cnt + 1'b1;
      end
      if (cs_rise && cnt_full) begin
        frame_word <= sreg_q;
        frame_vld  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_decoder.sv
module dac_decoder
  import dac_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_vld,
  input  logic [FRAME_W-1:0] frame_word,
  output dac_act_t           act_q,
  output logic [DATA_W-1:0]  data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      data_q <= '0;
    end else begin
      act_q <= '0;
      if (frame_vld) begin
        act_q  <= decode_cmd(frame_word[FRAME_W-1 -: CMD_W]);
        data_q <= frame_word[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int DATA_W = 12,
  parameter int RES    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              up,
  input  logic [DATA_W-1:0] din,
  output logic [RES-1:0]    in_q,
  output logic [RES-1:0]    dac_q
);
  logic [RES-1:0] code;
  assign code = din[DATA_W-1 -: RES];

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      if (ld) in_q <= code;
      if (up) dac_q <= ld ? code : in_q;
    end
  end
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_pkg::*;
#(
  parameter int DAC_BITS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_n,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                sdi,
  output logic                sdo,
  output logic [DAC_BITS-1:0] dac_a_code,
  output logic [DAC_BITS-1:0] dac_b_code
);
  logic               clr_n_s;
  logic               clr_act;
  logic               rst_all;
  logic [2:0]         pins_s;
  logic               cs_s;
  logic               sck_s;
  logic               sdi_s;
  logic [FRAME_W-1:0] sreg;
  logic               frame_vld;
  logic [FRAME_W-1:0] frame_word;
  dac_act_t           act;
  logic [DATA_W-1:0]  data;
  logic [NUM_CH-1:0]  ch_ld;
  logic [NUM_CH-1:0]  ch_up;
  logic [DAC_BITS-1:0] ch_in  [NUM_CH];
  logic [DAC_BITS-1:0] ch_dac [NUM_CH];

  dac_sync #(.W(1), .RST_VAL(1'b1)) u_clr_sync (
    .clk(clk), .rst(rst), .d(clr_n), .q(clr_n_s)
  );

  dac_sync #(.W(3), .RST_VAL(3'b100)) u_pin_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, sdi}), .q(pins_s)
  );

  assign cs_s    = pins_s[2];
  assign sck_s   = pins_s[1];
  assign sdi_s   = pins_s[0];
  assign clr_act = ~clr_n_s;
  assign rst_all = rst | clr_act;

  dac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst_all), .cs_n_s(cs_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .sreg_q(sreg), .frame_vld(frame_vld), .frame_word(frame_word)
  );

  dac_decoder u_dec (
    .clk(clk), .rst(rst_all), .frame_vld(frame_vld), .frame_word(frame_word),
    .act_q(act), .data_q(data)
  );

  assign ch_ld = {act.ld_b, act.ld_a};
  assign ch_up = {act.up_b, act.up_a};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dac_channel #(.DATA_W(DATA_W), .RES(DAC_BITS)) u_ch (
      .clk(clk), .rst(rst_all), .ld(ch_ld[ch]), .up(ch_up[ch]), .din(data),
      .in_q(ch_in[ch]), .dac_q(ch_dac[ch])
    );
  end

  assign sdo        = sreg[FRAME_W-1];
  assign dac_a_code = ch_dac[0];
  assign dac_b_code = ch_dac[1];
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk
  import dac_pkg::*;
#(
  parameter int RES = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               clr_act,
  input logic               cs_s,
  input logic [FRAME_W-1:0] sreg,
  input logic               frame_vld,
  input logic [FRAME_W-1:0] frame_word,
  input logic [1:0]         ch_ld,
  input logic [1:0]         ch_up,
  input logic [RES-1:0]     in_a,
  input logic [RES-1:0]     in_b,
  input logic [RES-1:0]     dac_a,
  input logic [RES-1:0]     dac_b
);
  a_r2_idle_cs_holds: assert property (@(posedge clk) disable iff (rst || clr_act)
    cs_s |=> $stable(sreg));

  a_r7_noop_silent: assert property (@(posedge clk) disable iff (rst || clr_act)
    (frame_vld && cmd_is_noop(frame_word[FRAME_W-1 -: CMD_W])) |=> (ch_ld == 2'b00 && ch_up == 2'b00));

  a_r8_out_a_needs_update: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_a) |-> $past(ch_up[0] || clr_act));

  a_r8_out_b_needs_update: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_b) |-> $past(ch_up[1] || clr_act));

  a_r4_update_copies_a: assert property (@(posedge clk) disable iff (rst || clr_act)
    (ch_up[0] && !ch_ld[0]) |=> (dac_a == $past(in_a)));

  a_r5_update_copies_b: assert property (@(posedge clk) disable iff (rst || clr_act)
    (ch_up[1] && !ch_ld[1]) |=> (dac_b == $past(in_b)));

  a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> (dac_a == '0 && dac_b == '0 && in_a == '0 && in_b == '0 && sreg == '0));

  a_r11_reset_zeroes: assert property (@(posedge clk)
    rst |=> (dac_a == '0 && dac_b == '0 && in_a == '0 && in_b == '0 && sreg == '0));
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.RES(DAC_BITS)) u_chk (
  .clk(clk), .rst(rst), .clr_act(clr_act), .cs_s(cs_s), .sreg(sreg),
  .frame_vld(frame_vld), .frame_word(frame_word), .ch_ld(ch_ld), .ch_up(ch_up),
  .in_a(ch_in[0]), .in_b(ch_in[1]), .dac_a(ch_dac[0]), .dac_b(ch_dac[1])
);

// File: tb/test_dual_dac_ctrl.sv
module test_dual_dac_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_n = 1'b1;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo;
  logic        sdo8;
  logic [11:0] a12, b12;
  logic [7:0]  a8, b8;
  int          checks = 0;
  int          errors = 0;
  logic [15:0] model = '0;

  always #2 clk = ~clk;

  dual_dac_ctrl #(.DAC_BITS(12)) i_dual_dac_ctrl (
    .clk(clk), .rst(rst), .clr_n(clr_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .dac_a_code(a12), .dac_b_code(b12)
  );

  dual_dac_ctrl #(.DAC_BITS(8)) i_dual_dac_ctrl_n8 (
    .clk(clk), .rst(rst), .clr_n(clr_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo8), .dac_a_code(a8), .dac_b_code(b8)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] bits, input int n, input string tag);
    int mism = 0;
    cs_n = 1'b0;
    tick(3);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      tick(3);
      if (sdo !== model[15]) mism++;
      model = {model[14:0], bits[i]};
      sck = 1'b1;
      tick(3);
      sck = 1'b0;
    end
    tick(3);
    cs_n = 1'b1;
    tick(12);
    chk(tag, mism, 0);
  endtask

  task automatic cmd(input logic [3:0] c, input logic [11:0] d);
    send({16'h0, c, d}, 16, "R9 sdo chain");
  endtask

  task automatic t_reset;
    chk("R11 reset a", a12, 0);
    chk("R11 reset b", b12, 0);
    chk("R11 reset sdo", sdo, 0);
  endtask

  task automatic t_chan_a;
    cmd(4'b0000, 12'hABC);
    chk("R8 staging-only a", a12, 12'h000);
    chk("R4 load a leaves b", b12, 12'h000);
    cmd(4'b0001, 12'h000);
    chk("R4 update a", a12, 12'hABC);
    chk("R12 8-bit a", a8, 8'hAB);
    cmd(4'b0010, 12'h123);
    chk("R4 load+update a", a12, 12'h123);
    chk("R1 frame order a", b12, 12'h000);
  endtask

  task automatic t_chan_b;
    cmd(4'b0011, 12'h456);
    chk("R8 staging-only b", b12, 12'h000);
    cmd(4'b0100, 12'hFFF);
    chk("R5 update b", b12, 12'h456);
    cmd(4'b0101, 12'h789);
    chk("R5 load+update b", b12, 12'h789);
    chk("R5 a untouched", a12, 12'h123);
    chk("R12 8-bit b", b8, 8'h78);
  endtask

  task automatic t_both;
    cmd(4'b1100, 12'h5A5);
    chk("R6 load both a", a12, 12'h123);
    chk("R6 load both b", b12, 12'h789);
    cmd(4'b1101, 12'h000);
    chk("R6 update both a", a12, 12'h5A5);
    chk("R6 update both b", b12, 12'h5A5);
    cmd(4'b1110, 12'h0F0);
    chk("R6 load+update both a", a12, 12'h0F0);
    chk("R6 load+update both b", b12, 12'h0F0);
  endtask

  task automatic t_noop;
    logic [3:0] codes [7] = '{4'b0110, 4'b0111, 4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b1111};
    for (int k = 0; k < 7; k++) begin
      cmd(codes[k], 12'h3C3);
      chk("R7 noop a", a12, 12'h0F0);
      chk("R7 noop b", b12, 12'h0F0);
    end
    cmd(4'b1101, 12'h000);
    chk("R7 staging kept a", a12, 12'h0F0);
    chk("R7 staging kept b", b12, 12'h0F0);
  endtask

  task automatic t_frame_len;
    send({17'h0, 4'b0010, 11'h7FF}, 15, "R9 sdo short");
    chk("R3 short frame", a12, 12'h0F0);
    send({12'h0, 4'b1111, 4'b0010, 12'h321}, 20, "R9 sdo long");
    chk("R3 long frame last bits", a12, 12'h321);
    chk("R3 long frame b", b12, 12'h0F0);
  endtask

  task automatic t_cs_gate;
    sdi = 1'b1;
    for (int k = 0; k < 10; k++) begin
      sck = 1'b1; tick(3);
      sck = 1'b0; tick(3);
    end
    send({16'h0, 4'b0110, 12'h000}, 16, "R2 sck ignored while deselected");
    chk("R2 codes kept", a12, 12'h321);
  endtask

  task automatic t_clear;
    cmd(4'b1100, 12'hEEE);
    clr_n = 1'b0;
    tick(6);
    clr_n = 1'b1;
    tick(6);
    model = '0;
    chk("R10 clear a", a12, 0);
    chk("R10 clear b", b12, 0);
    cmd(4'b1101, 12'h000);
    chk("R10 staging cleared a", a12, 0);
    chk("R10 staging cleared b", b12, 0);
  endtask

  task automatic t_rst_mid;
    cmd(4'b1110, 12'h9A9);
    chk("R6 pre-reset", a12, 12'h9A9);
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(3);
    model = '0;
    chk("R11 mid reset a", a12, 0);
    chk("R11 mid reset b", b12, 0);
    cmd(4'b0110, 12'h000);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_chan_a();
    t_chan_b();
    t_both();
    t_noop();
    t_frame_len();
    t_cs_gate();
    t_clear();
    t_rst_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule